// File: doc/BRIEF.md
# Two-Rank Crosspoint Router

This block routes a set of single-bit lanes from its inputs to its outputs. Every output lane picks any one input lane on its own, and one input may feed any number of outputs at once. Each output also carries a park flag. A parked output drives a constant 0 with its enable low, in place of a real high-impedance pad.

Routing is held in two ranks of per-output entries. A control port writes one pending entry at a time into the staging rank, and the routing does not change while it does so. A separate commit strobe then copies the whole staging rank into the live rank in one clock. All control lines are sampled on the system clock, and each strobe acts on its rising edge only, gated by a select line.

The lanes are continuous bit streams with no framing. An output cannot refuse data, so the lanes carry no valid/ready handshake and no back-pressure applies. An input bit reaches its routed outputs in the same cycle through combinational multiplexers.

Top module: `xbar_dbuf`

## Requirements
- R1: While and after reset (`rst_n` low), both ranks hold parked entries, so `lane_oe` and `lane_out` are all 0.
- R2: A live entry holds a source index and a park bit. An unparked output drives `lane_out[o] = lane_in[src]` with `lane_oe[o] = 1` in the same cycle. A parked output drives 0 with `lane_oe[o] = 0`.
- R3: A stage strobe writes `{src_addr, park}` into the staging entry chosen by `dst_addr`, with `src_addr` bit 2 as MSB. The live routing does not change until a commit.
- R4: A commit strobe copies every staging entry into the live rank in one cycle. The outputs change at the second rising clock edge on which the strobe is seen high.
- R5: While `sel` is low, the stage, commit and clear strobes are ignored and neither rank changes.
- R6: A clear strobe with `park` low sets every entry of both ranks to input 0, enabled.
- R7: A clear strobe with `park` high parks every entry of both ranks.
- R8: When a clear edge coincides with a stage or commit edge, only the clear takes effect.
- R9: When stage and commit edges coincide, the newly staged value is the one committed.
- R10: Each strobe acts once per high pulse. Address changes made while a strobe is held high are not written.
- R11: Staging an entry with `park` high and committing it parks that output. Staging with `park` low enables it on the chosen input.
- R12: Across a commit, an output whose live entry is unchanged keeps following its input with no interruption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, parks all entries |
| sel | input | 1 | Enables the three strobes when high |
| stage_stb | input | 1 | Rising edge writes one staging entry |
| commit_stb | input | 1 | Rising edge copies the staging rank to the live rank |
| clear_stb | input | 1 | Rising edge resets both ranks |
| park | input | 1 | Park bit for a write, or the clear mode |
| src_addr | input | 3 | Source lane index written into an entry |
| dst_addr | input | 3 | Output whose staging entry is written |
| lane_in | input | 8 | Input bit lanes |
| lane_out | output | 8 | Routed output bit lanes, 0 when parked |
| lane_oe | output | 8 | Per-output enable, low when parked |

## Verification
The bench builds the block with its defaults of eight inputs and eight outputs. This brings every 3-bit source and destination code within reach, including the top index 7, full fan-out of one input to all outputs, and a full reversing permutation. Strobes are held high for two cycles, so the once-per-pulse rule and the coincident-edge priorities are exercised at the ports. A clear followed by an empty commit shows that both ranks were reset.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // One-cycle control events after sampling, edge detection and priority.
  typedef struct packed {
    logic clear;
    logic stage;
    logic commit;
  } xbar_ev_t;
endpackage

// File: rtl/xbar_ctl.sv
module xbar_ctl
  import xbar_pkg::*;
#(
  parameter int SRC_W = 3,
  parameter int DST_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             stage_stb,
  input  logic             commit_stb,
  input  logic             clear_stb,
  input  logic             park,
  input  logic [SRC_W-1:0] src_addr,
  input  logic [DST_W-1:0] dst_addr,
  output xbar_ev_t         ev,
  output logic             sel_q,
  output logic             park_q,
  output logic [SRC_W-1:0] src_q,
  output logic [DST_W-1:0] dst_q
);
  logic [2:0] stb_q, stb_prev, rise;

  // All control lines are sampled together so data lines up with its strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q    <= '0;
      stb_prev <= '0;
      sel_q    <= 1'b0;
      park_q   <= 1'b1;
      src_q    <= '0;
      dst_q    <= '0;
    end else begin
      stb_q    <= {clear_stb, stage_stb, commit_stb};
      stb_prev <= stb_q;
      sel_q    <= sel;
      park_q   <= park;
      src_q    <= src_addr;
      dst_q    <= dst_addr;
    end
  end

  assign rise = stb_q & ~stb_prev & {3{sel_q}};

  // Clear overrides both other events.
  always_comb begin
    ev.clear  = rise[2];
    ev.stage  = rise[1] & ~rise[2];
    ev.commit = rise[0] & ~rise[2];
  end
endmodule

// File: rtl/xbar_ranks.sv
module xbar_ranks
  import xbar_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int SRC_W = 3,
  parameter int DST_W = 3,
  localparam int ENT_W = SRC_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  xbar_ev_t                     ev,
  input  logic                         park_q,
  input  logic [SRC_W-1:0]             src_q,
  input  logic [DST_W-1:0]             dst_q,
  output logic [N_OUT-1:0][ENT_W-1:0]  live
);
  localparam logic [ENT_W-1:0] PARKED = {{SRC_W{1'b0}}, 1'b1};

  logic [N_OUT-1:0][ENT_W-1:0] staged, staged_nxt;
  logic [ENT_W-1:0]            clr_ent;

  assign clr_ent = {{SRC_W{1'b0}}, park_q};

  for (genvar o = 0; o < N_OUT; o++) begin : g_ent
    // Forwarded value lets a coincident commit pick up the new write.
    assign staged_nxt[o] = (ev.stage && dst_q == DST_W'(o)) ? {src_q, park_q}
                                                             : staged[o];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged[o] <= PARKED;
        live[o]   <= PARKED;
      end else if (ev.clear) begin
        staged[o] <= clr_ent;
        live[o]   <= clr_ent;
      end else begin
        staged[o] <= staged_nxt[o];
        if (ev.commit) live[o] <= staged_nxt[o];
      end
    end
  end
endmodule

// File: rtl/xbar_lane.sv
module xbar_lane #(
  parameter int N_IN  = 8,
  parameter int SRC_W = 3
) (
  input  logic [N_IN-1:0]  lane_in,
  input  logic [SRC_W:0]   entry,
  output logic             bit_out,
  output logic             bit_oe
);
  logic [SRC_W-1:0] src;
  logic             hit;

  assign src     = entry[SRC_W:1];
  assign hit     = lane_in[src];
  assign bit_oe  = ~entry[0];
  assign bit_out = bit_oe & hit;
endmodule

// File: rtl/xbar_dbuf.sv
module xbar_dbuf
  import xbar_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  localparam int SRC_W = $clog2(N_IN),
  localparam int DST_W = $clog2(N_OUT),
  localparam int ENT_W = SRC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             stage_stb,
  input  logic             commit_stb,
  input  logic             clear_stb,
  input  logic             park,
  input  logic [SRC_W-1:0] src_addr,
  input  logic [DST_W-1:0] dst_addr,
  input  logic [N_IN-1:0]  lane_in,
  output logic [N_OUT-1:0] lane_out,
  output logic [N_OUT-1:0] lane_oe
);
  xbar_ev_t                    ev;
  logic                        sel_q, park_q;
  logic [SRC_W-1:0]            src_q;
  logic [DST_W-1:0]            dst_q;
  logic [N_OUT-1:0][ENT_W-1:0] live;

  xbar_ctl #(.SRC_W(SRC_W), .DST_W(DST_W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .stage_stb(stage_stb),
    .commit_stb(commit_stb), .clear_stb(clear_stb), .park(park),
    .src_addr(src_addr), .dst_addr(dst_addr), .ev(ev), .sel_q(sel_q),
    .park_q(park_q), .src_q(src_q), .dst_q(dst_q)
  );

  xbar_ranks #(.N_OUT(N_OUT), .SRC_W(SRC_W), .DST_W(DST_W)) ranks_i (
    .clk(clk), .rst_n(rst_n), .ev(ev), .park_q(park_q),
    .src_q(src_q), .dst_q(dst_q), .live(live)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane
    xbar_lane #(.N_IN(N_IN), .SRC_W(SRC_W)) lane_i (
      .lane_in(lane_in), .entry(live[o]),
      .bit_out(lane_out[o]), .bit_oe(lane_oe[o])
    );
  end
endmodule

// File: rtl/xbar_dbuf_chk.sv
module xbar_dbuf_chk
  import xbar_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int ENT_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input xbar_ev_t                    ev,
  input logic                        sel_q,
  input logic                        park_q,
  input logic [N_OUT-1:0][ENT_W-1:0] live,
  input logic [N_OUT-1:0]            lane_out,
  input logic [N_OUT-1:0]            lane_oe
);
  p_reset_parked_r1: assert property (@(posedge clk)
    !rst_n |=> lane_oe == '0);

  p_parked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_out & ~lane_oe) == '0);

  p_stage_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.stage && !ev.commit && !ev.clear) |=> $stable(live));

  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> $stable(live));

  p_clear_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.clear && !park_q) |=> lane_oe == '1);

  p_clear_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.clear && park_q) |=> lane_oe == '0);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev.clear |-> (!ev.stage && !ev.commit));

  p_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stage |=> !ev.stage);

  p_steady_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev.commit && !ev.clear) |=> $stable(live));
endmodule

bind xbar_dbuf xbar_dbuf_chk #(.N_OUT(N_OUT), .ENT_W(ENT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev(ev), .sel_q(sel_q), .park_q(park_q),
  .live(live), .lane_out(lane_out), .lane_oe(lane_oe)
);

// File: tb/xbar_dbuf_tb_top.sv
`timescale 1ns/1ps
module xbar_dbuf_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, stage_stb = 1'b0, commit_stb = 1'b0, clear_stb = 1'b0;
  logic       park = 1'b0;
  logic [2:0] src_addr = '0, dst_addr = '0;
  logic [7:0] lane_in = '0;
  logic [7:0] lane_out, lane_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int stg_src [8];
  bit stg_off [8];
  int act_src [8];
  bit act_off [8];

  always #2.5 clk = ~clk;

  xbar_dbuf dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .stage_stb(stage_stb),
    .commit_stb(commit_stb), .clear_stb(clear_stb), .park(park),
    .src_addr(src_addr), .dst_addr(dst_addr), .lane_in(lane_in),
    .lane_out(lane_out), .lane_oe(lane_oe)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_out(input logic [7:0] din);
    logic [7:0] r;
    for (int o = 0; o < 8; o++) r[o] = !act_off[o] && din[act_src[o]];
    return r;
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    for (int o = 0; o < 8; o++) r[o] = !act_off[o];
    return r;
  endfunction

  // R2: routing compared under several input patterns
  task automatic check_routing(input string tag);
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'h0F, 8'hC3};
    check({tag, " oe"}, lane_oe, exp_oe());
    for (int p = 0; p < 4; p++) begin
      lane_in = pats[p];
      #1;
      check({tag, " data"}, lane_out, exp_out(pats[p]));
    end
  endtask

  task automatic pulse(input bit s, input bit c, input bit r);
    sel = 1'b1;
    stage_stb = s; commit_stb = c; clear_stb = r;
    tick(2);
    stage_stb = 0; commit_stb = 0; clear_stb = 0;
    tick(2);
  endtask

  task automatic do_stage(input int dst, input int src, input bit pk);
    dst_addr = 3'(dst); src_addr = 3'(src); park = pk;
    pulse(1, 0, 0);
    stg_src[dst] = src; stg_off[dst] = pk;
  endtask

  task automatic do_commit();
    pulse(0, 1, 0);
    for (int o = 0; o < 8; o++) begin act_src[o] = stg_src[o]; act_off[o] = stg_off[o]; end
  endtask

  task automatic do_clear(input bit pk);
    park = pk;
    pulse(0, 0, 1);
    for (int o = 0; o < 8; o++) begin
      stg_src[o] = 0; stg_off[o] = pk; act_src[o] = 0; act_off[o] = pk;
    end
  endtask

  task automatic t_reset();
    lane_in = 8'hFF; #1;
    check("R1 oe after reset", lane_oe, 8'h00);
    check("R1 data after reset", lane_out, 8'h00);
  endtask

  task automatic t_permute();
    for (int o = 0; o < 8; o++) do_stage(o, 7 - o, 0);
    check_routing("R3 staged not live");
    do_commit();
    check_routing("R4 reversed permutation");
  endtask

  task automatic t_fanout();
    for (int o = 0; o < 8; o++) do_stage(o, 3, 0);
    do_commit();
    check_routing("R2 fan-out of input 3");
  endtask

  task automatic t_park();
    do_stage(2, 5, 1);
    do_stage(6, 7, 0);
    do_commit();
    check_routing("R11 park one output");
  endtask

  task automatic t_sel_low();
    logic [7:0] oe0;
    oe0 = lane_oe;
    dst_addr = 3'd0; src_addr = 3'd6; park = 0;
    sel = 0; stage_stb = 1; tick(2); stage_stb = 0; tick(2);
    commit_stb = 1; tick(2); commit_stb = 0; tick(2);
    clear_stb = 1; park = 1; tick(2); clear_stb = 0; tick(2);
    check("R5 oe with sel low", lane_oe, oe0);
    check_routing("R5 routing with sel low");
    do_commit();
    check_routing("R5 staging untouched");
  endtask

  task automatic t_clear_on();
    do_clear(0);
    check_routing("R6 clear to input 0");
    do_commit();
    check_routing("R6 staging also cleared");
  endtask

  task automatic t_clear_off();
    do_stage(4, 2, 0);
    do_clear(1);
    check_routing("R7 clear parks all");
    do_commit();
    check_routing("R7 staging also parked");
  endtask

  task automatic t_clear_wins();
    do_clear(0);
    dst_addr = 3'd1; src_addr = 3'd7; park = 1;
    pulse(1, 1, 1);
    for (int o = 0; o < 8; o++) begin
      stg_src[o] = 0; stg_off[o] = 1; act_src[o] = 0; act_off[o] = 1;
    end
    check_routing("R8 clear beats stage and commit");
    do_commit();
    check_routing("R8 stage was dropped");
  endtask

  task automatic t_stage_commit();
    do_clear(0);
    dst_addr = 3'd5; src_addr = 3'd6; park = 0;
    pulse(1, 1, 0);
    stg_src[5] = 6; stg_off[5] = 0;
    for (int o = 0; o < 8; o++) begin act_src[o] = stg_src[o]; act_off[o] = stg_off[o]; end
    check_routing("R9 coincident stage and commit");
  endtask

  task automatic t_once();
    do_clear(0);
    sel = 1; dst_addr = 3'd1; src_addr = 3'd4; park = 0;
    stage_stb = 1; tick(2);
    dst_addr = 3'd2; src_addr = 3'd5; tick(2);
    stage_stb = 0; tick(2);
    stg_src[1] = 4;
    do_commit();
    check_routing("R10 one write per pulse");
  endtask

  task automatic t_steady();
    bit ok;
    do_clear(0);
    do_stage(7, 6, 0);
    do_commit();
    do_stage(0, 2, 0);
    ok = 1;
    sel = 1; commit_stb = 1;
    for (int i = 0; i < 8; i++) begin
      lane_in = (i % 2) ? 8'h40 : 8'h00;
      #1;
      if (lane_out[7] !== lane_in[6] || lane_oe[7] !== 1'b1) ok = 0;
      if (i == 1) commit_stb = 0;
      tick(1);
    end
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R12 unchanged output disturbed: actual mismatch expected follow");
    end
    act_src[0] = 2;
    check_routing("R12 after commit");
  endtask

  initial begin
    for (int o = 0; o < 8; o++) begin
      stg_src[o] = 0; stg_off[o] = 1; act_src[o] = 0; act_off[o] = 1;
    end
    tick(3);
    t_reset();
    rst_n = 1;
    tick(2);
    t_reset();
    t_permute();
    t_fanout();
    t_park();
    t_sel_low();
    t_clear_on();
    t_clear_off();
    t_clear_wins();
    t_stage_commit();
    t_once();
    t_steady();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule